// File: doc/BRIEF.md
# Flash Embedded Operation Controller

This block is a cycle-based model of the command engine inside a byte-wide NOR-style flash. A host talks to it over an asynchronous-looking memory bus that is sampled on every clock: chip enable, output enable, write enable, an address and a bidirectional byte bus. Written command sequences start a byte program, an erase of chosen sectors or an erase of the whole array. Each operation then runs by itself as a timed internal sequence over a small register array of sixteen sectors. The host learns when it is done through status bits on the data bus or through a ready/busy pin.

Erases first drive every byte of each target sector to 00h and then set the whole sector to FFh. An erase may be suspended so the host can read the array or program a byte outside the sectors being erased, and then resumed. Eight protection inputs, one per pair of adjacent sectors, block program and erase in that pair. The host bus is a plain strobe interface with no back-pressure: a write or read is taken in the cycle its strobe is seen, and completion is learned only by status polling or ready/busy.

Top module: `flash_ctrl`

## Requirements
- R1: After rst_n rises, ry_by is 1, the controller is in read mode and every array byte reads FFh. A write cycle is ce_n=0, we_n=0, oe_n=1 at a clock edge; a read cycle is ce_n=0, oe_n=0, we_n=1, during which dq is driven combinationally, otherwise dq is high impedance.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then data D at address A stores old AND D at A. The byte address is addr[5:0], whose upper four bits are the sector. ry_by is low for exactly PROG_CYC (default 8) cycles after the data write, after which read mode resumes with no command.
- R3: While busy, any read returns bit 7 equal to the complement of the programmed data's bit 7 (program) or 0 (erase), bit 6 inverting on every successive read cycle, and bits 5..0 zero.
- R4: ry_by goes low in the cycle after the final write of a program or erase command and stays low until the operation ends.
- R5: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at an address in sector S selects S; each further 30h write within WIN_CYC (default 6) cycles adds its sector and restarts the window. Selected sectors become FFh; all other sectors are unchanged.
- R6: The same prefix followed by 10h@555h erases every unprotected sector to FFh.
- R7: grp_prot[g]=1 protects sectors 2g and 2g+1 against program and erase. A program, or an erase whose selection holds only protected sectors, keeps ry_by low for PROT_CYC (default 3) cycles and changes no data.
- R8: B0h written at any address while an erase is preprogramming or erasing suspends it: ry_by is 1 from the next cycle, reads return array contents, and 30h written while suspended (outside a command sequence) resumes the erase, which then completes.
- R9: While suspended, a program to a sector not being erased behaves as in R2 and returns to suspend; a program to a sector being erased is refused as in R7.
- R10: A write that does not match the next step of a command sequence returns the controller to read mode, so F0h or any stray value cancels a partial sequence and the following write is not taken as program data.
- R11: rst_n low aborts any running operation, forces read mode and ry_by high, and reinitialises the array to FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 11 | Byte address and command address |
| dq | inout | 8 | Data bus: command and program data in, array data or status out |
| grp_prot | input | 8 | One protection bit per pair of adjacent sectors |
| ry_by | output | 1 | High when ready or suspended, low while an operation runs |

## Verification
The assertions assume that grp_prot stays still while an operation is running, that write and read strobes are never asserted together, and that the bus inputs change only away from the rising clock edge. The stimulus drives every strobe and address at the falling edge, holds each for one full cycle, and changes the protection inputs only while ry_by is high. Under those conditions the checker relates decoder start pulses to ry_by, array writes to the protection map, consecutive status reads to the toggle bit, and suspend requests to the ready output.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    D_IDLE, D_UL1, D_UL2, D_PDATA, D_ER0, D_ER1, D_ER2
  } dec_st_t;

  typedef enum logic [2:0] {
    E_READ, E_PROG, E_PWAIT, E_COLLECT, E_PRE, E_ERASE, E_SUSP
  } eng_st_t;

  localparam logic [7:0]  K_UNLOCK_A = 8'hAA;
  localparam logic [7:0]  K_UNLOCK_B = 8'h55;
  localparam logic [7:0]  K_PROG     = 8'hA0;
  localparam logic [7:0]  K_ERASE    = 8'h80;
  localparam logic [7:0]  K_SECT     = 8'h30;
  localparam logic [7:0]  K_CHIP     = 8'h10;
  localparam logic [7:0]  K_SUSP     = 8'hB0;
  localparam logic [10:0] UL_ADDR_A  = 11'h555;
  localparam logic [10:0] UL_ADDR_B  = 11'h2AA;
endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        en,
  input  logic        erase_ok,
  input  logic [10:0] cmd_addr,
  input  logic [7:0]  din,
  output logic        go_prog,
  output logic        go_sect,
  output logic        go_chip,
  output logic        idle
);
  dec_st_t st, nxt;
  logic    hit, at_a, at_b;

  assign hit  = wr && en;
  assign at_a = (cmd_addr == UL_ADDR_A);
  assign at_b = (cmd_addr == UL_ADDR_B);
  assign idle = (st == D_IDLE);

  always_comb begin
    nxt     = D_IDLE;
    go_prog = 1'b0;
    go_sect = 1'b0;
    go_chip = 1'b0;
    case (st)
      D_IDLE:  if (at_a && din == K_UNLOCK_A) nxt = D_UL1;
      D_UL1:   if (at_b && din == K_UNLOCK_B) nxt = D_UL2;
      D_UL2: begin
        if (at_a && din == K_PROG) nxt = D_PDATA;
        else if (at_a && din == K_ERASE && erase_ok) nxt = D_ER0;
      end
      D_PDATA: go_prog = hit;
      D_ER0:   if (at_a && din == K_UNLOCK_A) nxt = D_ER1;
      D_ER1:   if (at_b && din == K_UNLOCK_B) nxt = D_ER2;
      D_ER2: begin
        if (din == K_SECT) go_sect = hit;
        else if (at_a && din == K_CHIP) go_chip = hit;
      end
      default: nxt = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= D_IDLE;
    else if (hit) st <= nxt;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int NSEC  = 16,
  parameter int OFF_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  logic [7:0]             wdata,
  input  logic                   erase_en,
  input  logic [NSEC-1:0]        erase_mask,
  input  logic [IDX_W-1:0]       ridx,
  output logic [7:0]             rdata
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int IDX_W = SEC_W + OFF_W;
  localparam int DEPTH = NSEC << OFF_W;

  logic [7:0] mem [DEPTH];

  assign rdata = mem[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (erase_mask[i >> OFF_W]) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[widx] <= mem[widx] & wdata;
    end
  end
endmodule

// File: rtl/flash_engine.sv
module flash_engine
  import flash_pkg::*;
#(
  parameter int NSEC      = 16,
  parameter int OFF_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int PROT_CYC  = 3,
  parameter int WIN_CYC   = 6,
  parameter int ERASE_CYC = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           din,
  input  logic                 go_prog,
  input  logic                 go_sect,
  input  logic                 go_chip,
  input  logic                 dec_idle,
  input  logic [NSEC/2-1:0]    grp_prot,
  output logic                 dec_en,
  output logic                 erase_ok,
  output logic                 busy,
  output logic                 susp_go,
  output logic                 arr_we,
  output logic [IDX_W-1:0]     arr_widx,
  output logic [7:0]           arr_wdata,
  output logic                 erase_en,
  output logic [NSEC-1:0]      erase_mask,
  output logic [7:0]           status
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int IDX_W = SEC_W + OFF_W;
  localparam int M1    = (PROG_CYC > PROT_CYC) ? PROG_CYC : PROT_CYC;
  localparam int M2    = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
  localparam int CMAX  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(CMAX + 1);

  eng_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [NSEC-1:0]  sel, prot_sec, sec_1h;
  logic [IDX_W-1:0] cursor, p_idx;
  logic [7:0]       p_data;
  logic             p_ret, p_isprog, era_phase, toggle;
  logic [SEC_W-1:0] in_sec, cur_sec;

  for (genvar s = 0; s < NSEC; s++) begin : g_prot
    assign prot_sec[s] = grp_prot[s/2];
  end

  assign in_sec  = idx[IDX_W-1 -: SEC_W];
  assign cur_sec = cursor[IDX_W-1 -: SEC_W];
  assign sec_1h  = NSEC'(1) << in_sec;
  assign busy    = (st != E_READ) && (st != E_SUSP);
  assign dec_en  = (st == E_READ) || (st == E_SUSP);
  assign erase_ok = (st == E_READ);
  assign susp_go = wr && din == K_SUSP && (st == E_PRE || st == E_ERASE);
  assign status  = {p_isprog ? ~p_data[7] : 1'b0, toggle, 6'b0};
  assign erase_mask = sel;

  always_comb begin
    arr_we    = 1'b0;
    arr_widx  = p_idx;
    arr_wdata = p_data;
    erase_en  = 1'b0;
    case (st)
      E_PROG:  arr_we = (cnt == '0);
      E_PRE: begin
        if (!susp_go && sel[cur_sec]) begin
          arr_we    = 1'b1;
          arr_widx  = cursor;
          arr_wdata = 8'h00;
        end
      end
      E_ERASE: erase_en = !susp_go && (cnt == '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_READ;
      cnt       <= '0;
      sel       <= '0;
      cursor    <= '0;
      p_idx     <= '0;
      p_data    <= '0;
      p_ret     <= 1'b0;
      p_isprog  <= 1'b0;
      era_phase <= 1'b0;
      toggle    <= 1'b0;
    end else begin
      if (rd && busy) toggle <= ~toggle;
      case (st)
        E_READ, E_SUSP: begin
          if (go_prog) begin
            p_idx    <= idx;
            p_data   <= din;
            p_isprog <= 1'b1;
            p_ret    <= (st == E_SUSP);
            if (prot_sec[in_sec] || (st == E_SUSP && sel[in_sec])) begin
              st  <= E_PWAIT;
              cnt <= CNT_W'(PROT_CYC - 1);
            end else begin
              st  <= E_PROG;
              cnt <= CNT_W'(PROG_CYC - 1);
            end
          end else if (st == E_READ && (go_sect || go_chip)) begin
            p_isprog <= 1'b0;
            p_ret    <= 1'b0;
            sel      <= go_chip ? '1 : sec_1h;
            cnt      <= go_chip ? '0 : CNT_W'(WIN_CYC - 1);
            st       <= E_COLLECT;
          end else if (st == E_SUSP && wr && din == K_SECT && dec_idle) begin
            p_isprog <= 1'b0;
            st       <= era_phase ? E_ERASE : E_PRE;
          end
        end
        E_PROG, E_PWAIT: begin
          if (cnt == '0) begin
            st <= p_ret ? E_SUSP : E_READ;
            if (p_ret) p_isprog <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_COLLECT: begin
          if (wr && din == K_SECT) begin
            sel <= sel | sec_1h;
            cnt <= CNT_W'(WIN_CYC - 1);
          end else if (cnt == '0) begin
            sel    <= sel & ~prot_sec;
            cursor <= '0;
            if ((sel & ~prot_sec) == '0) begin
              st  <= E_PWAIT;
              cnt <= CNT_W'(PROT_CYC - 1);
            end else begin
              st <= E_PRE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_PRE: begin
          if (susp_go) begin
            era_phase <= 1'b0;
            st        <= E_SUSP;
          end else begin
            cursor <= cursor + 1'b1;
            if (cursor == '1) begin
              st  <= E_ERASE;
              cnt <= CNT_W'(ERASE_CYC - 1);
            end
          end
        end
        E_ERASE: begin
          if (susp_go) begin
            era_phase <= 1'b1;
            st        <= E_SUSP;
          end else if (cnt == '0) begin
            sel <= '0;
            st  <= E_READ;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= E_READ;
      endcase
    end
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl #(
  parameter int NSEC      = 16,
  parameter int OFF_W     = 2,
  parameter int ADDR_W    = 11,
  parameter int PROG_CYC  = 8,
  parameter int PROT_CYC  = 3,
  parameter int WIN_CYC   = 6,
  parameter int ERASE_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [7:0]        dq,
  input  logic [NSEC/2-1:0] grp_prot,
  output logic              ry_by
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int IDX_W = SEC_W + OFF_W;

  logic             wr, rd, busy, dec_en, erase_ok, dec_idle;
  logic             go_prog, go_sect, go_chip, susp_go;
  logic             arr_we, erase_en;
  logic [IDX_W-1:0] arr_widx;
  logic [7:0]       arr_wdata, arr_rdata, status, din, rdata;
  logic [NSEC-1:0]  erase_mask;

  assign wr    = !ce_n && !we_n && oe_n;
  assign rd    = !ce_n && !oe_n && we_n;
  assign din   = dq;
  assign rdata = busy ? status : arr_rdata;
  assign dq    = rd ? rdata : 8'hzz;
  assign ry_by = !busy;

  flash_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr(wr), .en(dec_en), .erase_ok(erase_ok),
    .cmd_addr(addr[10:0]), .din(din),
    .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip), .idle(dec_idle)
  );

  flash_engine #(
    .NSEC(NSEC), .OFF_W(OFF_W), .PROG_CYC(PROG_CYC), .PROT_CYC(PROT_CYC),
    .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .idx(addr[IDX_W-1:0]), .din(din),
    .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip), .dec_idle(dec_idle),
    .grp_prot(grp_prot), .dec_en(dec_en), .erase_ok(erase_ok), .busy(busy),
    .susp_go(susp_go), .arr_we(arr_we), .arr_widx(arr_widx), .arr_wdata(arr_wdata),
    .erase_en(erase_en), .erase_mask(erase_mask), .status(status)
  );

  flash_array #(.NSEC(NSEC), .OFF_W(OFF_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .widx(arr_widx), .wdata(arr_wdata),
    .erase_en(erase_en), .erase_mask(erase_mask),
    .ridx(addr[IDX_W-1:0]), .rdata(arr_rdata)
  );
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk #(
  parameter int NGRP  = 8,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             oe_n,
  input logic             we_n,
  input wire  [7:0]       dq,
  input logic [NGRP-1:0]  grp_prot,
  input logic             ry_by,
  input logic             go_prog,
  input logic             go_sect,
  input logic             go_chip,
  input logic             susp_go,
  input logic             arr_we,
  input logic [IDX_W-1:0] arr_widx
);
  localparam int GRP_W = $clog2(NGRP);

  logic rd, up_q;
  logic [GRP_W-1:0] wgrp;
  assign rd   = !ce_n && !oe_n && we_n;
  assign wgrp = arr_widx[IDX_W-1 -: GRP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  // R1: ready in the first cycle after reset
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !up_q |-> ry_by);

  // R4: a started operation pulls ready/busy low next cycle
  a_r4_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_sect || go_chip) |=> !ry_by);

  // R3: consecutive status reads see bit 6 change
  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && rd && !ry_by && $past(rd && !ry_by)) |-> (dq[6] != $past(dq[6])));

  // R7: no array write lands in a protected group
  a_r7_no_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !grp_prot[wgrp]);

  // R8: a suspend request makes the device ready next cycle
  a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |=> ry_by);
endmodule

bind flash_ctrl flash_ctrl_chk #(.NGRP(NSEC/2), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq(dq),
  .grp_prot(grp_prot), .ry_by(ry_by), .go_prog(go_prog), .go_sect(go_sect),
  .go_chip(go_chip), .susp_go(susp_go), .arr_we(arr_we), .arr_widx(arr_widx)
);

// File: tb/sim_flash_ctrl.sv
module sim_flash_ctrl;
  localparam int PROG_CYC = 8;
  localparam int PROT_CYC = 3;
  localparam int WIN_CYC  = 6;
  localparam int NV       = 60;
  // vector = {op[1:0], addr[10:0], data[7:0]}; op 0 write, 1 read+compare, 2 wait ready
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 11'h008, 8'hFF},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h008, 8'hA5},
    {2'd2, 11'h000, 8'h00}, {2'd1, 11'h008, 8'hA5},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h008, 8'h3C},
    {2'd2, 11'h000, 8'h00}, {2'd1, 11'h008, 8'h24},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h030, 8'h00},
    {2'd2, 11'h000, 8'h00}, {2'd1, 11'h030, 8'hFF},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h014, 8'h5A},
    {2'd2, 11'h000, 8'h00}, {2'd1, 11'h014, 8'h5A},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'h80},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h008, 8'h30},
    {2'd2, 11'h000, 8'h00}, {2'd1, 11'h008, 8'hFF}, {2'd1, 11'h014, 8'h5A},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h01C, 8'h11},
    {2'd2, 11'h000, 8'h00},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h024, 8'h22},
    {2'd2, 11'h000, 8'h00},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'hA0}, {2'd0, 11'h028, 8'h33},
    {2'd2, 11'h000, 8'h00},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55}, {2'd0, 11'h555, 8'h80},
    {2'd0, 11'h555, 8'hAA}, {2'd0, 11'h2AA, 8'h55},
    {2'd0, 11'h01C, 8'h30}, {2'd0, 11'h024, 8'h30},
    {2'd2, 11'h000, 8'h00},
    {2'd1, 11'h01C, 8'hFF}, {2'd1, 11'h024, 8'hFF}, {2'd1, 11'h028, 8'h33}
  };

  logic        clk = 1'b0;
  logic        rst_n, ce_n, oe_n, we_n, dq_oe;
  logic [10:0] addr;
  logic [7:0]  dq_drv, grp_prot;
  wire  [7:0]  dq;
  wire         ry_by;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;
  assign dq = dq_oe ? dq_drv : 8'hzz;

  flash_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq(dq), .grp_prot(grp_prot), .ry_by(ry_by)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; dq_drv = d; dq_oe = 1'b1;
    #2;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; dq_oe = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; dq_oe = 1'b0;
    #2;
    v = dq;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (ry_by !== 1'b1 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic prog(input logic [10:0] a, input logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre;
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  function automatic string vreq(input int i);
    if (i == 0) return "R1";
    if (i >= 13 && i < 19) return "R7";
    if (i < 25) return "R2";
    return "R5";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int n;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; dq_oe = 1'b0;
    addr = '0; dq_drv = '0; grp_prot = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ry_by === 1'b1, "R1 ready after reset", ry_by, 1);

    // table walk: R1, R2, R5, R7
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][20:19])
        2'd0: wr(VEC[i][18:8], VEC[i][7:0]);
        2'd1: begin
          rd(VEC[i][18:8], v);
          chk(v === VEC[i][7:0], vreq(i), v, VEC[i][7:0]);
        end
        default: begin
          wait_rdy(n);
          chk(n < 2000, vreq(i), n, 0);
        end
      endcase
    end

    // R2 R3 R4: busy length and status during a program
    prog(11'h02C, 8'h7E);
    chk(ry_by === 1'b0, "R4 busy after data write", ry_by, 0);
    rd(11'h000, v);
    rd(11'h3FF, v2);
    chk(v[7] === 1'b1 && v2[7] === 1'b1, "R3 bit7 complement", v, 8'h80);
    chk(v[6] !== v2[6], "R3 bit6 toggles", v2, v ^ 8'h40);
    chk(v[5:0] === 6'd0, "R3 low bits zero", v, 0);
    wait_rdy(n);
    chk(n == PROG_CYC - 2, "R2 program busy cycles", n + 2, PROG_CYC);
    rd(11'h02C, v);
    chk(v === 8'h7E, "R2 programmed value", v, 8'h7E);

    prog(11'h018, 8'h81);
    wait_rdy(n);
    chk(n == PROG_CYC, "R2 busy length", n, PROG_CYC);
    rd(11'h018, v);
    chk(v === 8'h81, "R2 read back", v, 8'h81);

    // R7: protected program is short and harmless
    prog(11'h034, 8'h00);
    wait_rdy(n);
    chk(n == PROT_CYC, "R7 protected busy", n, PROT_CYC);
    rd(11'h034, v);
    chk(v === 8'hFF, "R7 data unchanged", v, 8'hFF);

    // R10: broken and cancelled sequences
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h00); wr(11'h555, 8'hA0); wr(11'h008, 8'h12);
    chk(ry_by === 1'b1, "R10 stray write no op", ry_by, 1);
    rd(11'h008, v);
    chk(v === 8'hFF, "R10 data kept", v, 8'hFF);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hF0); wr(11'h008, 8'h00);
    chk(ry_by === 1'b1, "R10 cancel no op", ry_by, 1);
    rd(11'h008, v);
    chk(v === 8'hFF, "R10 cancel data kept", v, 8'hFF);

    // R8 R9: suspend an erase of sector 3
    erase_pre();
    wr(11'h00C, 8'h30);
    repeat (WIN_CYC + 4) @(negedge clk);
    chk(ry_by === 1'b0, "R8 erase running", ry_by, 0);
    wr(11'h000, 8'hB0);
    chk(ry_by === 1'b1, "R8 ready when suspended", ry_by, 1);
    rd(11'h014, v);
    chk(v === 8'h5A, "R8 array read in suspend", v, 8'h5A);
    prog(11'h01A, 8'hC3);
    wait_rdy(n);
    chk(n == PROG_CYC, "R9 program in suspend", n, PROG_CYC);
    rd(11'h01A, v);
    chk(v === 8'hC3, "R9 suspend program data", v, 8'hC3);
    prog(11'h00D, 8'h00);
    wait_rdy(n);
    chk(n == PROT_CYC, "R9 erasing sector refused", n, PROT_CYC);
    wr(11'h000, 8'h30);
    chk(ry_by === 1'b0, "R8 resumed busy", ry_by, 0);
    rd(11'h000, v);
    chk(v[7] === 1'b0, "R3 erase bit7 zero", v, 0);
    wait_rdy(n);
    chk(n < 2000, "R8 resumed erase ends", n, 0);
    rd(11'h00C, v);
    chk(v === 8'hFF, "R8 sector erased", v, 8'hFF);
    rd(11'h01A, v);
    chk(v === 8'hC3, "R5 other sector kept", v, 8'hC3);

    // R6 R7: chip erase with group 6 protected
    grp_prot = 8'h00;
    prog(11'h030, 8'h66);
    wait_rdy(n);
    grp_prot = 8'h40;
    erase_pre();
    wr(11'h555, 8'h10);
    chk(ry_by === 1'b0, "R4 chip erase busy", ry_by, 0);
    wait_rdy(n);
    rd(11'h030, v);
    chk(v === 8'h66, "R7 protected kept in chip erase", v, 8'h66);
    rd(11'h014, v);
    chk(v === 8'hFF, "R6 chip erased", v, 8'hFF);
    rd(11'h02C, v);
    chk(v === 8'hFF, "R6 chip erased high sector", v, 8'hFF);

    // R7: erase aimed only at protected sector
    erase_pre();
    wr(11'h030, 8'h30);
    wait_rdy(n);
    chk(n == WIN_CYC + PROT_CYC, "R7 protected erase time", n, WIN_CYC + PROT_CYC);
    rd(11'h030, v);
    chk(v === 8'h66, "R7 protected erase no change", v, 8'h66);

    // R11: reset aborts a program
    prog(11'h020, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(ry_by === 1'b1, "R11 ready after abort", ry_by, 1);
    rd(11'h020, v);
    chk(v === 8'hFF, "R11 array reinitialised", v, 8'hFF);
    prog(11'h020, 8'h0F);
    wait_rdy(n);
    rd(11'h020, v);
    chk(v === 8'h0F, "R11 read mode after abort", v, 8'h0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule